// File: doc/BRIEF.md
# NAND Ready/Busy Timeout Monitor

This block watches the ready/busy line of a NAND flash device and raises a timeout error when the device stays busy longer than a programmed number of clock cycles. The line is active-low busy and asynchronous, so it first passes through a synchronizer. Each time the device enters busy, a down-counter is loaded from a 20-bit timeout setting. The counter then decrements once per clock while the device stays busy. If it reaches zero, a sticky error flag is set. A timeout setting of zero turns the check off.

Software reaches the block through a small word-addressed register port. The port has three registers: the timeout setting, a control word, and a read-only status word. The control word holds the error flag, which software clears by writing 1 to it, and an interrupt enable. The status word packs the last status byte that the command sequencer read from the flash together with the live counter value. The interrupt output is the error flag gated by the enable.

Top module: `nand_rb_timeout_mon`

## Requirements
- R1: The timeout setting at word address 0 holds 20 bits in positions 19:0, resets to 0, reads back what was written, and bits 31:20 always read as 0.
- R2: The ready/busy input `rb_n` is low for busy and passes through a two-flop synchronizer. On the falling edge of the synchronized signal, the counter loads the timeout setting. After `rb_n` falls between two clock edges, the loaded value is visible from the third rising edge.
- R3: While busy, the counter decrements once per clock. With a setting of N > 0, the error flag and the interrupt (if enabled) go high on the (N+3)th rising edge after `rb_n` falls, and not before.
- R4: With a setting of 0, no error is raised, however long the device stays busy.
- R5: If the device returns to ready before the count reaches 0, the counter holds its value and no error is raised.
- R6: The counter does not wrap below 0. Once it reaches 0, it stays at 0 until the next busy entry.
- R7: The error flag is bit 0 of the control word at address 1. It is sticky, resets to 0, and is cleared by writing 1 to bit 0. If a timeout occurs on the same edge as the clear, the flag stays set.
- R8: The interrupt enable is bit 1 of the control word and resets to 0. `irq` is a registered output equal to the error flag AND the enable, and it updates on the same edge as either of them.
- R9: The read-only status word at address 2 carries the flash status byte in bits 31:24, zeros in bits 23:20 and the live counter in bits 19:0. It resets to 0. Address 3 reads as 0. Read data is registered and reflects the address presented before the rising edge.
- R10: The status byte is captured only on a clock where `sts_valid` is high. Between strobes it keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| rb_n | input | 1 | Asynchronous ready/busy line, low means busy |
| sts_valid | input | 1 | Strobe from the sequencer marking a new status byte |
| sts_byte | input | 8 | Status byte read back from the flash |
| bus_addr | input | 2 | Word address of the register port |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Timeout interrupt request |

## Verification
The bench counts edges from the moment `rb_n` falls. It checks the interrupt one cycle before and one cycle on the exact edge of expiry. A design that missed a synchronizer stage, or fired at count 1 instead of 0, would be one cycle early or late. It releases busy mid-count and checks that the frozen counter value is exact. A design that kept decrementing, or that reloaded on ready, would show a different value or a spurious error. It programs a zero timeout and holds the device busy for a long time, which catches a counter that wraps to all ones and later expires. It also lands a write-1-to-clear on the expiry edge, where a design giving priority to the clear would lose the error.

// File: rtl/nrb_pkg.sv
package nrb_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    REG_TMO  = 2'd0,
    REG_CTRL = 2'd1,
    REG_STAT = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int CTRL_ERR_BIT = 0;
  localparam int CTRL_IE_BIT  = 1;
endpackage

// File: rtl/nrb_sync.sv
module nrb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rb_n,
  output logic busy,
  output logic busy_entry
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= rb_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b1;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b1;
    else     last_q <= chain[STAGES-1];
  end

  assign busy       = ~chain[STAGES-1];
  assign busy_entry = last_q & ~chain[STAGES-1];

  a_r2_entry_single: assert property (@(posedge clk) disable iff (rst)
    busy_entry |=> !busy_entry);
endmodule

// File: rtl/nrb_countdown.sv
module nrb_countdown #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic             load,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] cnt_q;

  assign expire = busy & ~load & (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (rst)                        cnt_q <= ZERO;
    else if (load)                  cnt_q <= reload_val;
    else if (busy && cnt_q != ZERO) cnt_q <= cnt_q - ONE;
  end

  assign count = cnt_q;

  a_r2_reload: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt_q == $past(reload_val));
  a_r5_hold_ready: assert property (@(posedge clk) disable iff (rst)
    (!busy && !load) |=> $stable(cnt_q));
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (busy && !load && cnt_q == ZERO) |=> cnt_q == ZERO);
  a_r3_expire_hits_zero: assert property (@(posedge clk) disable iff (rst)
    expire |=> cnt_q == ZERO);
endmodule

// File: rtl/nrb_regs.sv
module nrb_regs
  import nrb_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int STS_W  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              sts_valid,
  input  logic [STS_W-1:0]  sts_byte,
  input  logic [CNT_W-1:0]  count,
  input  logic              expire,
  output logic [CNT_W-1:0]  tmo_cfg,
  output logic              irq
);
  localparam int PAD_W = WORD_W - STS_W - CNT_W;

  logic [CNT_W-1:0] tmo_q;
  logic [STS_W-1:0] sts_q;
  logic             err_q, ie_q, irq_q;
  logic             err_d, ie_d, clr_req;
  logic             wr_tmo, wr_ctrl;
  logic [WORD_W-1:0] rd_mux;

  assign wr_tmo  = bus_wr && (bus_addr == ADDR_W'(REG_TMO));
  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(REG_CTRL));
  assign clr_req = wr_ctrl & bus_wdata[CTRL_ERR_BIT];
  assign err_d   = expire | (err_q & ~clr_req);
  assign ie_d    = wr_ctrl ? bus_wdata[CTRL_IE_BIT] : ie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_q <= '0;
      sts_q <= '0;
      err_q <= 1'b0;
      ie_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (wr_tmo)    tmo_q <= bus_wdata[CNT_W-1:0];
      if (sts_valid) sts_q <= sts_byte;
      err_q <= err_d;
      ie_q  <= ie_d;
      irq_q <= err_d & ie_d;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(REG_TMO):  rd_mux[CNT_W-1:0] = tmo_q;
      ADDR_W'(REG_CTRL): begin
        rd_mux[CTRL_ERR_BIT] = err_q;
        rd_mux[CTRL_IE_BIT]  = ie_q;
      end
      ADDR_W'(REG_STAT): rd_mux = {sts_q, {PAD_W{1'b0}}, count};
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  assign tmo_cfg = tmo_q;
  assign irq     = irq_q;

  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (err_q && !clr_req) |=> err_q);
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    expire |=> err_q);
  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (ie_q && err_q));
  a_r10_sts_hold: assert property (@(posedge clk) disable iff (rst)
    !sts_valid |=> $stable(sts_q));
endmodule

// File: rtl/nand_rb_timeout_mon.sv
module nand_rb_timeout_mon
  import nrb_pkg::*;
#(
  parameter int CNT_W       = 20,
  parameter int STS_W       = 8,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rb_n,
  input  logic              sts_valid,
  input  logic [STS_W-1:0]  sts_byte,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  logic             busy, busy_entry, expire;
  logic [CNT_W-1:0] count, tmo_cfg;

  nrb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .rb_n(rb_n),
    .busy(busy), .busy_entry(busy_entry)
  );

  nrb_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .busy(busy), .load(busy_entry),
    .reload_val(tmo_cfg), .count(count), .expire(expire)
  );

  nrb_regs #(.CNT_W(CNT_W), .STS_W(STS_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sts_valid(sts_valid),
    .sts_byte(sts_byte), .count(count), .expire(expire),
    .tmo_cfg(tmo_cfg), .irq(irq)
  );

  a_r4_zero_never_expires: assert property (@(posedge clk) disable iff (rst)
    (busy_entry && tmo_cfg == '0) |=> (count == '0 && !expire));
endmodule

// File: tb/test_nand_rb_timeout_mon.sv
module test_nand_rb_timeout_mon;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rb_n = 1'b1;
  logic        sts_valid = 1'b0;
  logic [7:0]  sts_byte = '0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    rd_pend = 1'b0;
  bit    finished = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  nand_rb_timeout_mon i_nand_rb_timeout_mon (
    .clk(clk), .rst(rst), .rb_n(rb_n), .sts_valid(sts_valid),
    .sts_byte(sts_byte), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: queue the expected word, present the address
  task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_pend = 1'b1;
    @(posedge clk);
    #2;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // monitor: pop and compare once the registered data is out
  initial forever begin
    @(posedge clk);
    if (rd_pend) begin
      #1;
      check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      rd_pend = 1'b0;
    end
  end

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 R7 R9 R8 reset state
    rd(2'd0, 32'h0, "R1 reset tmo");
    rd(2'd1, 32'h0, "R7 reset ctrl");
    rd(2'd2, 32'h0, "R9 reset status");
    rd(2'd3, 32'h0, "R9 unused address");
    @(negedge clk) check("R8 reset irq", irq, 0);

    // R1 upper bits drop
    wr(2'd0, 32'hFFF1_2345);
    rd(2'd0, 32'h0001_2345, "R1 upper bits zero");

    // R10 status byte capture only on strobe
    @(negedge clk); sts_byte = 8'hA5; sts_valid = 1'b1;
    @(negedge clk); sts_valid = 1'b0; sts_byte = 8'h3C;
    repeat (3) @(negedge clk);
    rd(2'd2, 32'hA500_0000, "R10 byte held between strobes");

    // R3 expiry edge with N=10
    wr(2'd0, 32'd10);
    wr(2'd1, 32'h2);
    @(negedge clk) rb_n = 1'b0;
    repeat (12) @(posedge clk);
    @(negedge clk) check("R3 no irq one edge early", irq, 0);
    @(posedge clk);
    @(negedge clk) check("R3 irq at expiry edge", irq, 1);
    repeat (5) @(negedge clk);
    rd(2'd2, 32'hA500_0000, "R6 counter stays at zero");
    rd(2'd1, 32'h3, "R7 flag set");

    // R7 clear while busy at zero
    wr(2'd1, 32'h3);
    repeat (5) @(negedge clk);
    check("R7 irq after clear", irq, 0);
    rd(2'd1, 32'h2, "R7 flag cleared");

    // R5 ready before expiry
    @(negedge clk) rb_n = 1'b1;
    wr(2'd0, 32'd20);
    repeat (4) @(negedge clk);
    @(negedge clk) rb_n = 1'b0;
    repeat (8) @(posedge clk);
    @(negedge clk) rb_n = 1'b1;
    repeat (30) @(negedge clk);
    rd(2'd2, 32'hA500_000D, "R5 counter frozen");
    check("R5 no irq", irq, 0);
    rd(2'd1, 32'h2, "R5 no error flag");

    // R4 zero disables
    wr(2'd0, 32'd0);
    @(negedge clk) rb_n = 1'b0;
    repeat (100) @(negedge clk);
    check("R4 no irq with zero setting", irq, 0);
    rd(2'd1, 32'h2, "R4 no error flag");
    rd(2'd2, 32'hA500_0000, "R4 counter reloaded zero");

    // R8 enable gating
    @(negedge clk) rb_n = 1'b1;
    wr(2'd1, 32'h0);
    wr(2'd0, 32'd5);
    repeat (4) @(negedge clk);
    @(negedge clk) rb_n = 1'b0;
    repeat (20) @(negedge clk);
    check("R8 irq gated off", irq, 0);
    rd(2'd1, 32'h1, "R8 flag set without enable");
    wr(2'd1, 32'h2);
    check("R8 irq follows enable", irq, 1);

    // R7 set wins over clear on the expiry edge
    @(negedge clk) rb_n = 1'b1;
    wr(2'd0, 32'd4);
    repeat (4) @(negedge clk);
    @(negedge clk) rb_n = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    bus_addr = 2'd1; bus_wdata = 32'h3; bus_wr = 1'b1;
    @(negedge clk) bus_wr = 1'b0;
    check("R7 set wins irq", irq, 1);
    rd(2'd1, 32'h3, "R7 set wins flag");
    wr(2'd1, 32'h3);
    check("R7 plain clear", irq, 0);

    // R2 reload on busy entry
    @(negedge clk) rb_n = 1'b1;
    wr(2'd0, 32'd50);
    repeat (4) @(negedge clk);
    @(negedge clk) rb_n = 1'b0;
    repeat (3) @(posedge clk);
    rd(2'd2, 32'hA500_0032, "R2 loaded value");
    rd(2'd2, 32'hA500_0031, "R3 first decrement");

    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule